// File: doc/BRIEF.md
# Phase-Angle Triac Firing Controller

This block times the gate signal of a triac against a mains zero-crossing strobe. Each accepted strobe restarts a tick counter, and the block latches the requested firing delay, pulse width, drive style and cycle mode. One tick is one clock cycle, and `HALF_TICKS` is the length of one mains half period in ticks. When the counter reaches the latched delay, the gate fires. A longer delay means a smaller conduction angle in the half cycle, and a shorter delay means a larger one.

There are two cycle modes. In half-cycle mode a crossing detector strobes on every crossing, and the block fires once per strobe. In full-cycle mode the detector strobes only on one reference crossing per line cycle. The block then fires twice: once at the delay, and again exactly `HALF_TICKS` later, so both polarities see the same angle.

There are three gate drive styles:
- A single pulse of programmable width.
- A burst of carrier pulses over the same window, for driving a pulse transformer.
- A steady level that stays asserted from the first firing for as long as `enable` is high.

The control is a state machine with these states:
- `ST_IDLE`: disabled.
- `ST_ARMED`: waiting for the first firing.
- `ST_FIRE1`: first gate window.
- `ST_GAP`: waiting for the second firing.
- `ST_FIRE2`: second gate window.
- `ST_HOLD`: steady drive.
- `ST_DONE`: waiting for the next strobe.

The transitions are:
- Any state goes to `ST_IDLE` when `enable` is low.
- An accepted strobe goes to `ST_ARMED`, or to `ST_DONE` when the delay is at least a half period.
- `ST_ARMED` goes to `ST_FIRE1` on the delay match, or to `ST_HOLD` when steady drive is latched.
- `ST_FIRE1` goes to `ST_GAP` when the width has run out in full-cycle mode, and to `ST_DONE` otherwise.
- `ST_GAP` goes to `ST_FIRE2` on the match at delay plus half period.
- `ST_FIRE2` goes to `ST_DONE` when its width has run out.
- `ST_HOLD` leaves only when `enable` falls.

Top module: `phase_fire_ctrl`

## Requirements
- R1: While reset is active, or in any cycle after an edge that sampled `enable` low, `gate_out` is 0. A strobe seen while `enable` is low is ignored.
- R2: Let E0 be the edge that samples an accepted strobe with delay D below `HALF_TICKS`. The first firing makes `gate_out` active starting right after edge E(D+1).
- R3: Delay, pulse width, drive style and cycle mode are captured only at an accepted strobe. Changes to those inputs at other times have no effect on the firing in progress.
- R4: When `full_cycle` was 1 at the strobe, a second firing with the same window shape starts right after edge E(D+HALF_TICKS+1).
- R5: When `full_cycle` was 0 at the strobe, exactly one firing occurs per strobe.
- R6: With `drive_mode` 2'b00 (single pulse), `gate_out` is high for P consecutive cycles per firing, where P is the latched width. A width of 0 acts as 1, and a width of at least `HALF_TICKS` acts as `HALF_TICKS`-1.
- R7: With `drive_mode` 2'b01 (carrier burst), the window lasts the same P cycles. In cycle j of the window (j from 0), `gate_out` is 1 when floor(j/`CARRIER_HALF`) is even, and 0 otherwise.
- R8: With `drive_mode` 2'b10 (steady), `gate_out` goes high at the first firing and stays high, ignoring strobes, until an edge samples `enable` low.
- R9: A latched delay of `HALF_TICKS` or more suppresses every firing for that strobe.
- R10: An accepted strobe during a pulse or burst window ends that window at the sampling edge and starts new timing from that edge.
- R11: `drive_mode` 2'b11 behaves exactly like single-pulse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Firing enable; low forces the gate off and the controller idle |
| sync_strobe | input | 1 | One-cycle zero-crossing strobe |
| full_cycle | input | 1 | 1: two firings per strobe, half a period apart; 0: one firing |
| drive_mode | input | 2 | 00 pulse, 01 carrier burst, 10 steady, 11 pulse |
| delay_ticks | input | WIDTH | Firing delay from the strobe, in ticks |
| pulse_ticks | input | WIDTH | Gate window width, in ticks |
| gate_out | output | 1 | Triac gate drive |

## Verification
The bench checks the exact first-firing cycle at both delay extremes, 0 and `HALF_TICKS`-1. An off-by-one counter would shift every firing and the conduction angle with it. At a delay of exactly `HALF_TICKS` it checks that nothing fires; a design that compared with the wrong inequality would fire a stray pulse at the next crossing. The bench scrambles the delay, width and mode inputs right after every strobe, so a design that does not latch them changes angle mid half-cycle. It also checks the second firing in full-cycle mode, width clamping, restart on a strobe during a window, and steady drive that ignores strobes and falls only with `enable`; wrong handling shows up as an asymmetric second pulse, overlapping windows or a gate that drops too early.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_FIRE1 = 3'd2,
        ST_GAP   = 3'd3,
        ST_FIRE2 = 3'd4,
        ST_HOLD  = 3'd5,
        ST_DONE  = 3'd6
    } fire_state_t;

    typedef enum logic [1:0] {
        DRV_PULSE  = 2'b00,
        DRV_TRAIN  = 2'b01,
        DRV_STEADY = 2'b10,
        DRV_ALT    = 2'b11
    } drive_t;

endpackage

// File: rtl/pf_phase_timer.sv
module pf_phase_timer #(
    parameter int PH_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] PH_MAX = '1;

    // Ticks since the last accepted strobe; saturates at its maximum.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clear) begin
            phase <= '0;
        end else if (phase != PH_MAX) begin
            phase <= phase + 1'b1;
        end
    end

    // Guards R2: the count always moves by one between strobes until it saturates.
    a_r2_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && phase != PH_MAX) |=> (phase == $past(phase) + 1'b1));

endmodule

// File: rtl/pf_width_timer.sv
module pf_width_timer #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_len,
    input  logic             run,
    output logic             done
);
    logic [WIDTH-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_len - 1'b1;
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);

    a_r6_width_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && remain != '0) |=> (remain == $past(remain) - 1'b1));

    a_r6_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_len != '0));

endmodule

// File: rtl/pf_carrier.sv
module pf_carrier #(
    parameter int CARRIER_HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic level
);
    localparam int CW = (CARRIER_HALF > 1) ? $clog2(CARRIER_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(CARRIER_HALF - 1);

    logic [CW-1:0] tick;

    // Square wave: high for CARRIER_HALF cycles, then low for CARRIER_HALF cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick  <= '0;
            level <= 1'b1;
        end else if (restart) begin
            tick  <= '0;
            level <= 1'b1;
        end else if (tick == LAST) begin
            tick  <= '0;
            level <= ~level;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    a_r7_carrier_range: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= LAST);

    a_r7_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> level);

endmodule

// File: rtl/phase_fire_ctrl.sv
module phase_fire_ctrl
    import pf_pkg::*;
#(
    parameter int WIDTH        = 12,
    parameter int HALF_TICKS   = 120,
    parameter int CARRIER_HALF = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sync_strobe,
    input  logic             full_cycle,
    input  logic [1:0]       drive_mode,
    input  logic [WIDTH-1:0] delay_ticks,
    input  logic [WIDTH-1:0] pulse_ticks,
    output logic             gate_out
);
    localparam int              PH_W    = WIDTH + 1;
    localparam logic [WIDTH-1:0] HALF_W  = WIDTH'(HALF_TICKS);
    localparam logic [PH_W-1:0]  HALF_PH = PH_W'(HALF_TICKS);

    fire_state_t      st, st_nxt;
    logic             strobe_ok;
    logic [WIDTH-1:0] lat_delay;
    logic [WIDTH-1:0] lat_width;
    drive_t           lat_mode;
    logic             lat_full;
    logic [WIDTH-1:0] width_eff;
    logic [PH_W-1:0]  phase;
    logic [PH_W-1:0]  mark_first;
    logic [PH_W-1:0]  mark_second;
    logic             fire_now;
    logic             win_run;
    logic             win_done;
    logic             car_level;

    // A strobe is taken when enabled, except while steady drive holds the gate.
    assign strobe_ok = enable && sync_strobe && (st != ST_HOLD);

    // Clamp the requested width into 1 .. HALF_TICKS-1.
    always_comb begin
        if (pulse_ticks == '0) begin
            width_eff = WIDTH'(1);
        end else if (pulse_ticks >= HALF_W) begin
            width_eff = HALF_W - 1'b1;
        end else begin
            width_eff = pulse_ticks;
        end
    end

    // Capture the firing settings at accepted strobes only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_delay <= '0;
            lat_width <= WIDTH'(1);
            lat_mode  <= DRV_PULSE;
            lat_full  <= 1'b0;
        end else if (strobe_ok) begin
            lat_delay <= delay_ticks;
            lat_width <= width_eff;
            lat_mode  <= drive_t'(drive_mode);
            lat_full  <= full_cycle;
        end
    end

    assign mark_first  = {1'b0, lat_delay};
    assign mark_second = {1'b0, lat_delay} + HALF_PH;

    pf_phase_timer #(.PH_W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (strobe_ok),
        .phase (phase)
    );

    // Next-state logic.
    always_comb begin
        st_nxt = st;
        if (!enable) begin
            st_nxt = ST_IDLE;
        end else if (strobe_ok) begin
            st_nxt = (delay_ticks >= HALF_W) ? ST_DONE : ST_ARMED;
        end else begin
            unique case (st)
                ST_IDLE:  st_nxt = ST_IDLE;
                ST_ARMED: begin
                    if (phase == mark_first) begin
                        st_nxt = (lat_mode == DRV_STEADY) ? ST_HOLD : ST_FIRE1;
                    end
                end
                ST_FIRE1: begin
                    if (win_done) begin
                        st_nxt = lat_full ? ST_GAP : ST_DONE;
                    end
                end
                ST_GAP: begin
                    if (phase == mark_second) begin
                        st_nxt = ST_FIRE2;
                    end
                end
                ST_FIRE2: begin
                    if (win_done) begin
                        st_nxt = ST_DONE;
                    end
                end
                ST_HOLD:  st_nxt = ST_HOLD;
                ST_DONE:  st_nxt = ST_DONE;
                default:  st_nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    assign fire_now = enable && !strobe_ok &&
                      (((st == ST_ARMED) && (st_nxt == ST_FIRE1)) ||
                       ((st == ST_GAP)   && (st_nxt == ST_FIRE2)));
    assign win_run  = (st == ST_FIRE1) || (st == ST_FIRE2);

    pf_width_timer #(.WIDTH(WIDTH)) u_width (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fire_now),
        .load_len (lat_width),
        .run      (win_run),
        .done     (win_done)
    );

    pf_carrier #(.CARRIER_HALF(CARRIER_HALF)) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fire_now),
        .level   (car_level)
    );

    // Output decode.
    always_comb begin
        gate_out = 1'b0;
        unique case (st)
            ST_FIRE1, ST_FIRE2: gate_out = (lat_mode == DRV_TRAIN) ? car_level : 1'b1;
            ST_HOLD:            gate_out = 1'b1;
            default:            gate_out = 1'b0;
        endcase
    end

    a_r1_disabled_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !gate_out);

    a_r2_first_fire_on_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_FIRE1 || st == ST_HOLD) && $past(st) == ST_ARMED)
            |-> ($past(phase) == $past(mark_first)));

    a_r4_second_fire_half_later: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRE2 && $past(st) == ST_GAP)
            |-> ($past(phase) == $past(mark_first) + HALF_PH));

    a_r3_latch_only_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_ok |=> ($stable(lat_delay) && $stable(lat_width) && $stable(lat_full)));

    a_r8_steady_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && enable) |=> gate_out);

    a_r9_no_arm_when_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED) |-> (lat_delay < HALF_W));

    a_r5_half_mode_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP || st == ST_FIRE2) |-> lat_full);

endmodule

// File: tb/phase_fire_ctrl_tb.sv
module phase_fire_ctrl_tb;

    localparam int WIDTH = 12;
    localparam int HALF  = 120;
    localparam int CH    = 3;
    localparam int NSAMP = 2 * HALF + 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             sync_strobe = 1'b0;
    logic             full_cycle = 1'b0;
    logic [1:0]       drive_mode = 2'b00;
    logic [WIDTH-1:0] delay_ticks = '0;
    logic [WIDTH-1:0] pulse_ticks = '0;
    logic             gate_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int seed_dummy;

    phase_fire_ctrl #(.WIDTH(WIDTH), .HALF_TICKS(HALF), .CARRIER_HALF(CH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .sync_strobe (sync_strobe),
        .full_cycle  (full_cycle),
        .drive_mode  (drive_mode),
        .delay_ticks (delay_ticks),
        .pulse_ticks (pulse_ticks),
        .gate_out    (gate_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, cycles=%0d expected<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int eff_width(int p);
        if (p == 0) return 1;
        if (p >= HALF) return HALF - 1;
        return p;
    endfunction

    function automatic bit in_window(int k, int start, int pe, int md);
        int j;
        j = k - start;
        if (j < 0 || j >= pe) return 1'b0;
        if (md == 1) return ((j / CH) % 2) == 0;
        return 1'b1;
    endfunction

    // Expected gate level after edge E(k) following the strobe edge E0.
    function automatic bit exp_gate(int k, int d, int p, bit full, int md);
        int k1;
        int pe;
        if (d >= HALF) return 1'b0;
        k1 = d + 1;
        pe = eff_width(p);
        if (md == 2) return k >= k1;
        if (in_window(k, k1, pe, md)) return 1'b1;
        if (full && in_window(k, k1 + HALF, pe, md)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check1(bit act, bit exp, string tag);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s gate=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Strobe, scramble the inputs (R3), then compare nsamp cycles with the model.
    task automatic run_case(int d, int p, bit full, int md, int nsamp, string tag);
        int bad_k;
        bit bad_act;
        bit bad_exp;
        bad_k = -1;
        bad_act = 1'b0;
        bad_exp = 1'b0;
        @(negedge clk);
        delay_ticks = WIDTH'(d);
        pulse_ticks = WIDTH'(p);
        full_cycle  = full;
        drive_mode  = 2'(md);
        sync_strobe = 1'b1;
        @(negedge clk);
        sync_strobe = 1'b0;
        delay_ticks = WIDTH'($urandom_range(0, HALF + 20));
        pulse_ticks = WIDTH'($urandom_range(0, HALF + 20));
        full_cycle  = 1'($urandom_range(0, 1));
        drive_mode  = 2'($urandom_range(0, 3));
        for (int k = 1; k <= nsamp; k++) begin
            @(negedge clk);
            if (bad_k < 0 && gate_out !== exp_gate(k, d, p, full, md)) begin
                bad_k = k;
                bad_act = gate_out;
                bad_exp = exp_gate(k, d, p, full, md);
            end
        end
        checks = checks + 1;
        if (bad_k >= 0) begin
            errors = errors + 1;
            $display("FAIL %s d=%0d p=%0d full=%0b mode=%0d at k=%0d gate=%0b expected=%0b",
                     tag, d, p, full, md, bad_k, bad_act, bad_exp);
        end
    endtask

    // Steady hold: a strobe is ignored, then enable low drops the gate.
    task automatic steady_tail(string tag);
        @(negedge clk);
        delay_ticks = '0;
        drive_mode  = 2'b00;
        sync_strobe = 1'b1;
        @(negedge clk);
        sync_strobe = 1'b0;
        for (int i = 0; i < 6; i++) @(negedge clk);
        check1(gate_out, 1'b1, {tag, " R8 strobe ignored in hold"});
        enable = 1'b0;
        @(negedge clk);
        check1(gate_out, 1'b0, {tag, " R1 enable low drops gate"});
        enable = 1'b1;
        @(negedge clk);
    endtask

    function automatic string mode_tag(int md);
        case (md)
            0: return "R6 pulse";
            1: return "R7 train";
            2: return "R8 steady";
            default: return "R11 alt";
        endcase
    endfunction

    initial begin
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check1(gate_out, 1'b0, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check1(gate_out, 1'b0, "R1 disabled after reset");
        enable = 1'b1;
        repeat (3) @(negedge clk);
        check1(gate_out, 1'b0, "R1 enabled without strobe");

        run_case(0, 1, 1'b0, 0, NSAMP, "R2 zero delay R5 single");
        run_case(7, 0, 1'b0, 0, NSAMP, "R6 zero width acts as one");
        run_case(HALF - 1, 5, 1'b1, 0, NSAMP, "R4 max delay second fire");
        run_case(HALF, 5, 1'b1, 0, NSAMP, "R9 delay equal half suppressed");
        run_case(HALF + 9, 5, 1'b0, 1, NSAMP, "R9 delay above half suppressed");
        run_case(3, HALF + 7, 1'b0, 0, NSAMP, "R6 width clamp");
        run_case(20, 20, 1'b1, 1, NSAMP, "R7 train full");
        run_case(10, 4, 1'b1, 3, NSAMP, "R11 alt as pulse");
        run_case(10, 30, 1'b0, 0, 15, "R10 before restart");
        run_case(5, 4, 1'b0, 0, NSAMP, "R10 restart mid window");
        run_case(30, 9, 1'b1, 2, NSAMP, "R8 steady");
        steady_tail("R8 directed");

        // Strobe while disabled is ignored.
        enable = 1'b0;
        @(negedge clk);
        delay_ticks = WIDTH'(2);
        pulse_ticks = WIDTH'(5);
        drive_mode  = 2'b00;
        sync_strobe = 1'b1;
        @(negedge clk);
        sync_strobe = 1'b0;
        begin
            bit seen;
            seen = 1'b0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (gate_out) seen = 1'b1;
            end
            check1(seen, 1'b0, "R1 strobe ignored while disabled");
        end
        enable = 1'b1;
        repeat (5) @(negedge clk);
        check1(gate_out, 1'b0, "R1 no late fire after enable");

        for (int n = 0; n < 40; n++) begin
            int d;
            int p;
            int md;
            bit fl;
            if ($urandom_range(0, 4) == 0) d = $urandom_range(HALF, HALF + 30);
            else d = $urandom_range(0, HALF - 1);
            p  = $urandom_range(0, HALF + 10);
            md = $urandom_range(0, 3);
            fl = 1'($urandom_range(0, 1));
            run_case(d, p, fl, md, NSAMP, {"R2 R3 R4 R5 random ", mode_tag(md)});
            if (md == 2 && d < HALF) steady_tail("R8 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule